// File: doc/BRIEF.md
# Binary and Decimal Add/Subtract Unit

This block is the add, subtract and compare engine of an 8-bit processor datapath. It takes an accumulator byte, an operand byte, a carry input, a decimal-mode bit and a two-bit operation code. One clock edge later it presents a registered result byte, the four arithmetic flags (negative, overflow, zero, carry) and a write-enable for each of them. The surrounding register file uses these enables to decide what it commits.

Binary mode works as two's-complement arithmetic with carry. Decimal mode treats each byte as two packed BCD digits. It applies fixed nibble correction sequences, and these give a defined answer for every byte value, including bytes with hexadecimal digits A to F. Compare is a subtraction that leaves the result and the overflow flag alone. It produces the equality and unsigned-ordering flags.

Top module: `bcd_arith_unit`

## Requirements
- R1: While reset is asserted, the result, all four flags and all five write-enables read 0. Reset takes effect without waiting for a clock edge.
- R2: `op_sel` encodes 00 = idle, 01 = add, 10 = subtract, 11 = compare. Outputs reflect the operands present at the clock edge after they are applied. An idle cycle drives every write-enable low and leaves the result and flags unchanged. Add and subtract drive all five enables high.
- R3: Binary add (`dec_mode`=0) yields r = A + B + Cin. The result is r mod 256, C is set when r > 255, and V is bit 7 of ~(A^B) & (A^r).
- R4: Binary subtract yields A + ~B + Cin, where Cin = 1 means no borrow. C and V follow the R3 rules with ~B in place of B.
- R5: In binary add, binary subtract and decimal subtract, N is bit 7 of the binary sum and Z is set when that sum's low byte is zero.
- R6: Decimal add forms a low digit L = A[3:0] + B[3:0] + Cin and replaces it with ((L+6) & $0F) + $10 when L >= 10. It then forms S = (A & $F0) + (B & $F0) + L and adds $60 when S >= $A0. The result is S mod 256, and C = (S >= $100).
- R7: In decimal add, N and V come from the corrected L added to the high nibbles, with each high nibble taken as a signed byte: N is bit 7 of that sum, and V is set when the sum lies outside -128..127. Z is set when the final decimal result is $00.
- R8: Decimal subtract forms L = A[3:0] - B[3:0] + Cin - 1 and replaces it with ((L-6) & $0F) - $10 when L < 0. It then forms S = (A & $F0) - (B & $F0) + L and subtracts $60 when S < 0. The result is S mod 256. All four flags equal those of binary subtract on the same inputs.
- R9: Compare ignores `dec_mode` and `carry_in` and behaves as a subtract with carry-in 1: Z = (A == B), C = (A >= B) unsigned, and N is bit 7 of A - B.
- R10: Compare drives `res_we` and `we_v` low and `we_n`, `we_z` and `we_c` high, and leaves `res_q` and `flag_v` at their previous values.
- R11: Bytes that are not valid BCD go through the same decimal sequences without any special case (for example, $0F + $0F in decimal gives $14).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_sel | input | 2 | Operation: 00 idle, 01 add, 10 subtract, 11 compare |
| dec_mode | input | 1 | 1 selects packed-BCD arithmetic for add and subtract |
| carry_in | input | 1 | Carry input (1 = no borrow for subtract) |
| acc_a | input | 8 | Accumulator operand |
| opnd_b | input | 8 | Second operand |
| res_q | output | 8 | Registered result byte |
| res_we | output | 1 | Result should be written back |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| we_n | output | 1 | Negative flag should be written |
| we_v | output | 1 | Overflow flag should be written |
| we_z | output | 1 | Zero flag should be written |
| we_c | output | 1 | Carry flag should be written |

## Verification
The hardest cases to reach are the decimal adds where N and V split away from the carry and zero result: the signed high-part sum crosses bit 7 or overflows, while the $60 correction wraps the result to $00. The stimulus table includes $99+$01 and $58+$46 with carry set for these cases, along with subtractions whose low digit borrows. Invalid-BCD bytes such as $0F and $9A are also applied, so the correction sequences run outside the digit range. The no-change behaviour of compare is observed after an add that leaves overflow set and a nonzero result, so a wrongly updated V or result shows up at the ports.

// File: rtl/bcd_arith_pkg.sv
`timescale 1ns/1ps
package bcd_arith_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned NW = DW / 2;

  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_ADD  = 2'b01,
    OP_SUB  = 2'b10,
    OP_CMP  = 2'b11
  } arith_op_e;
endpackage

// File: rtl/bin_adder_core.sv
`timescale 1ns/1ps
module bin_adder_core
  import bcd_arith_pkg::*;
(
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] b_in,
  input  logic          cin,
  input  logic          invert_b,
  input  logic          force_cin,
  output logic [DW-1:0] sum,
  output logic          n_out,
  output logic          v_out,
  output logic          z_out,
  output logic          c_out
);
  logic [DW-1:0] b_eff;
  logic          c_eff;
  logic [DW:0]   wide;

  always_comb begin
    b_eff = invert_b ? ~b_in : b_in;
    c_eff = force_cin ? 1'b1 : cin;
    wide  = {1'b0, a_in} + {1'b0, b_eff} + {{DW{1'b0}}, c_eff};
    sum   = wide[DW-1:0];
    c_out = wide[DW];
    n_out = wide[DW-1];
    z_out = (wide[DW-1:0] == '0);
    v_out = ~(a_in[DW-1] ^ b_eff[DW-1]) & (a_in[DW-1] ^ wide[DW-1]);
  end

  always_comb begin
    if (force_cin && invert_b)
      AST_CMP_CARRY_ORDER: assert (c_out == (a_in >= b_in)); // R9
  end
endmodule

// File: rtl/bcd_add_seq.sv
`timescale 1ns/1ps
module bcd_add_seq
  import bcd_arith_pkg::*;
(
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] b_in,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          c_out,
  output logic          n_out,
  output logic          v_out
);
  logic        [NW:0]   lo_raw;
  logic        [NW:0]   lo_fix;
  logic        [NW:0]   hi_pair;
  logic        [DW:0]   u_sum;
  logic        [DW+1:0] u_fix;
  logic signed [DW+1:0] s_sum;

  always_comb begin
    lo_raw  = {1'b0, a_in[NW-1:0]} + {1'b0, b_in[NW-1:0]} + {{NW{1'b0}}, cin};
    lo_fix  = (lo_raw >= 5'd10) ? {1'b1, lo_raw[NW-1:0] + 4'd6} : lo_raw;
    hi_pair = {1'b0, a_in[DW-1:NW]} + {1'b0, b_in[DW-1:NW]};
    u_sum   = {hi_pair, 4'b0000} + {4'b0000, lo_fix};
    u_fix   = (u_sum >= 9'h0A0) ? ({1'b0, u_sum} + 10'h060) : {1'b0, u_sum};
    res     = u_fix[DW-1:0];
    c_out   = (u_fix >= 10'h100);
    s_sum   = $signed({{2{a_in[DW-1]}}, a_in[DW-1:NW], 4'b0000})
            + $signed({{2{b_in[DW-1]}}, b_in[DW-1:NW], 4'b0000})
            + $signed({5'b00000, lo_fix});
    n_out   = s_sum[DW-1];
    v_out   = (s_sum > 10'sd127) || (s_sum < -10'sd128);
  end

  always_comb begin
    if (a_in[7:4] <= 4'd9 && a_in[3:0] <= 4'd9 && b_in[7:4] <= 4'd9 && b_in[3:0] <= 4'd9)
      AST_BCD_ADD_DIGITS: assert (res[7:4] <= 4'd9 && res[3:0] <= 4'd9); // R6
  end
endmodule

// File: rtl/bcd_sub_seq.sv
`timescale 1ns/1ps
module bcd_sub_seq
  import bcd_arith_pkg::*;
(
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] b_in,
  input  logic          cin,
  output logic [DW-1:0] res
);
  logic signed [NW:0] lo_raw;
  logic signed [NW:0] lo_fix;
  logic signed [DW:0] s_sum;

  always_comb begin
    lo_raw = $signed({1'b0, a_in[NW-1:0]}) - $signed({1'b0, b_in[NW-1:0]})
           + $signed({4'b0000, cin}) - 5'sd1;
    lo_fix = lo_raw[NW] ? $signed({1'b1, lo_raw[NW-1:0] - 4'd6}) : lo_raw;
    s_sum  = $signed({1'b0, a_in[DW-1:NW], 4'b0000})
           - $signed({1'b0, b_in[DW-1:NW], 4'b0000})
           + $signed({{4{lo_fix[NW]}}, lo_fix});
    res    = s_sum[DW-1:0] - (s_sum[DW] ? 8'h60 : 8'h00);
  end

  always_comb begin
    if (a_in[7:4] <= 4'd9 && a_in[3:0] <= 4'd9 && b_in[7:4] <= 4'd9 && b_in[3:0] <= 4'd9)
      AST_BCD_SUB_DIGITS: assert (res[7:4] <= 4'd9 && res[3:0] <= 4'd9); // R8
  end
endmodule

// File: rtl/bcd_arith_unit.sv
`timescale 1ns/1ps
module bcd_arith_unit
  import bcd_arith_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    op_sel,
  input  logic          dec_mode,
  input  logic          carry_in,
  input  logic [DW-1:0] acc_a,
  input  logic [DW-1:0] opnd_b,
  output logic [DW-1:0] res_q,
  output logic          res_we,
  output logic          flag_n,
  output logic          flag_v,
  output logic          flag_z,
  output logic          flag_c,
  output logic          we_n,
  output logic          we_v,
  output logic          we_z,
  output logic          we_c
);
  arith_op_e     op;
  logic [1:0]    rst_pipe;
  logic          rst_ok;

  logic [DW-1:0] bin_sum, dadd_res, dsub_res;
  logic          bin_n, bin_v, bin_z, bin_c;
  logic          dadd_c, dadd_n, dadd_v;

  logic [DW-1:0] res_nx;
  logic          n_nx, v_nx, z_nx, c_nx;
  logic          res_we_nx, we_n_nx, we_v_nx, we_z_nx, we_c_nx;
  logic          load_en;

  assign op = arith_op_e'(op_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ok = rst_pipe[1];

  bin_adder_core u_bin (
    .a_in(acc_a), .b_in(opnd_b), .cin(carry_in),
    .invert_b(op == OP_SUB || op == OP_CMP), .force_cin(op == OP_CMP),
    .sum(bin_sum), .n_out(bin_n), .v_out(bin_v), .z_out(bin_z), .c_out(bin_c)
  );

  bcd_add_seq u_dadd (
    .a_in(acc_a), .b_in(opnd_b), .cin(carry_in),
    .res(dadd_res), .c_out(dadd_c), .n_out(dadd_n), .v_out(dadd_v)
  );

  bcd_sub_seq u_dsub (
    .a_in(acc_a), .b_in(opnd_b), .cin(carry_in), .res(dsub_res)
  );

  always_comb begin
    res_nx = res_q;
    n_nx = flag_n; v_nx = flag_v; z_nx = flag_z; c_nx = flag_c;
    res_we_nx = 1'b0; we_n_nx = 1'b0; we_v_nx = 1'b0; we_z_nx = 1'b0; we_c_nx = 1'b0;
    load_en = 1'b1;
    unique case (op)
      OP_ADD: begin
        res_nx = dec_mode ? dadd_res : bin_sum;
        n_nx   = dec_mode ? dadd_n : bin_n;
        v_nx   = dec_mode ? dadd_v : bin_v;
        z_nx   = dec_mode ? (dadd_res == '0) : bin_z;
        c_nx   = dec_mode ? dadd_c : bin_c;
        {res_we_nx, we_n_nx, we_v_nx, we_z_nx, we_c_nx} = 5'b11111;
      end
      OP_SUB: begin
        res_nx = dec_mode ? dsub_res : bin_sum;
        n_nx = bin_n; v_nx = bin_v; z_nx = bin_z; c_nx = bin_c;
        {res_we_nx, we_n_nx, we_v_nx, we_z_nx, we_c_nx} = 5'b11111;
      end
      OP_CMP: begin
        n_nx = bin_n; z_nx = bin_z; c_nx = bin_c;
        {we_n_nx, we_z_nx, we_c_nx} = 3'b111;
      end
      default: load_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      res_q  <= '0;
      flag_n <= 1'b0; flag_v <= 1'b0; flag_z <= 1'b0; flag_c <= 1'b0;
      res_we <= 1'b0; we_n <= 1'b0; we_v <= 1'b0; we_z <= 1'b0; we_c <= 1'b0;
    end else begin
      res_we <= res_we_nx; we_n <= we_n_nx; we_v <= we_v_nx;
      we_z   <= we_z_nx;   we_c <= we_c_nx;
      if (load_en) begin
        res_q  <= res_nx;
        flag_n <= n_nx; flag_v <= v_nx; flag_z <= z_nx; flag_c <= c_nx;
      end
    end
  end

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_sel == 2'b00) |=> ($stable(res_q) && $stable(flag_z) && !res_we && !we_c)); // R2
  AST_CMP_KEEPS_V_RES: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_sel == 2'b11) |=> ($stable(res_q) && $stable(flag_v) && !we_v && !res_we)); // R10
  AST_CMP_EQUAL: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_sel == 2'b11 && acc_a == opnd_b) |=> (flag_z && flag_c)); // R9
  AST_DEC_SUB_FLAGS: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_sel == 2'b10 && dec_mode && acc_a == opnd_b && carry_in) |=> (flag_z && flag_c && res_q == 8'h00)); // R8
endmodule

// File: tb/bcd_arith_unit_test.sv
`timescale 1ns/1ps
module bcd_arith_unit_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] op_sel;
  logic       dec_mode, carry_in;
  logic [7:0] acc_a, opnd_b;
  logic [7:0] res_q;
  logic       res_we, flag_n, flag_v, flag_z, flag_c, we_n, we_v, we_z, we_c;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bcd_arith_unit uut (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .dec_mode(dec_mode),
    .carry_in(carry_in), .acc_a(acc_a), .opnd_b(opnd_b), .res_q(res_q),
    .res_we(res_we), .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z),
    .flag_c(flag_c), .we_n(we_n), .we_v(we_v), .we_z(we_z), .we_c(we_c)
  );

  // {op[1:0], dec, cin, a[7:0], b[7:0], result[7:0], N V Z C}
  localparam logic [31:0] VECS [15] = '{
    {2'd1, 1'b0, 1'b0, 8'h50, 8'h50, 8'hA0, 4'b1100},
    {2'd1, 1'b0, 1'b0, 8'hFF, 8'h01, 8'h00, 4'b0011},
    {2'd1, 1'b0, 1'b0, 8'h19, 8'h28, 8'h41, 4'b0000},
    {2'd2, 1'b0, 1'b1, 8'h05, 8'h03, 8'h02, 4'b0001},
    {2'd2, 1'b0, 1'b1, 8'h80, 8'h01, 8'h7F, 4'b0101},
    {2'd2, 1'b0, 1'b1, 8'h03, 8'h05, 8'hFE, 4'b1000},
    {2'd1, 1'b1, 1'b0, 8'h99, 8'h01, 8'h00, 4'b1011},
    {2'd1, 1'b1, 1'b0, 8'h19, 8'h28, 8'h47, 4'b0000},
    {2'd1, 1'b1, 1'b1, 8'h58, 8'h46, 8'h05, 4'b1101},
    {2'd2, 1'b1, 1'b1, 8'h46, 8'h12, 8'h34, 4'b0001},
    {2'd2, 1'b1, 1'b1, 8'h40, 8'h13, 8'h27, 4'b0001},
    {2'd2, 1'b1, 1'b1, 8'h00, 8'h01, 8'h99, 4'b1000},
    {2'd2, 1'b1, 1'b0, 8'h50, 8'h01, 8'h48, 4'b0001},
    {2'd1, 1'b1, 1'b0, 8'h0F, 8'h0F, 8'h14, 4'b0000},
    {2'd1, 1'b1, 1'b0, 8'h9A, 8'h00, 8'h00, 4'b1011}
  };

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic apply(input logic [1:0] op, input logic d, input logic c,
                       input logic [7:0] a, input logic [7:0] b);
    op_sel = op; dec_mode = d; carry_in = c; acc_a = a; opnd_b = b;
    @(negedge clk);
  endtask

  function automatic string res_tag(input int idx, input logic [1:0] op, input logic d);
    if (idx >= 13) return "R11";
    if (op == 2'd1) return d ? "R6" : "R3";
    return d ? "R8" : "R4";
  endfunction

  function automatic string flag_tag(input logic [1:0] op, input logic d);
    if (op == 2'd1 && d) return "R7";
    if (op == 2'd2 && d) return "R8";
    return "R5";
  endfunction

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    op_sel = 2'b01; dec_mode = 1'b0; carry_in = 1'b1; acc_a = 8'h33; opnd_b = 8'h44;
    repeat (3) @(negedge clk);
    chk("R1", "result in reset", res_q, 0);
    chk("R1", "flags in reset", {flag_n, flag_v, flag_z, flag_c}, 0);
    chk("R1", "enables in reset", {res_we, we_n, we_v, we_z, we_c}, 0);
    op_sel = 2'b00;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < 15; i++) begin
      logic [31:0] v;
      v = VECS[i];
      apply(v[31:30], v[29], v[28], v[27:20], v[19:12]);
      chk(res_tag(i, v[31:30], v[29]), $sformatf("row %0d result", i), res_q, v[11:4]);
      chk(flag_tag(v[31:30], v[29]), $sformatf("row %0d NVZC", i),
          {flag_n, flag_v, flag_z, flag_c}, v[3:0]);
      chk("R2", $sformatf("row %0d enables", i), {res_we, we_n, we_v, we_z, we_c}, 5'b11111);
    end

    // R10: compare after an add that left V=1 and result $A0
    apply(2'd1, 1'b0, 1'b0, 8'h50, 8'h50);
    apply(2'd3, 1'b1, 1'b0, 8'h40, 8'h40);
    chk("R9", "cmp equal N Z C", {flag_n, flag_z, flag_c}, 3'b011);
    chk("R10", "cmp keeps result", res_q, 8'hA0);
    chk("R10", "cmp keeps V", flag_v, 1);
    chk("R10", "cmp enables", {res_we, we_n, we_v, we_z, we_c}, 5'b01011);
    apply(2'd3, 1'b1, 1'b1, 8'h10, 8'h20);
    chk("R9", "cmp less N Z C", {flag_n, flag_z, flag_c}, 3'b100);
    chk("R10", "cmp keeps result again", res_q, 8'hA0);
    apply(2'd3, 1'b0, 1'b0, 8'hFF, 8'h00);
    chk("R9", "cmp greater N Z C", {flag_n, flag_z, flag_c}, 3'b101);
    chk("R10", "cmp keeps V again", flag_v, 1);

    // R2: idle holds everything and drops the enables
    apply(2'd0, 1'b1, 1'b1, 8'h77, 8'h11);
    chk("R2", "idle result", res_q, 8'hA0);
    chk("R2", "idle flags", {flag_n, flag_v, flag_z, flag_c}, 4'b1101);
    chk("R2", "idle enables", {res_we, we_n, we_v, we_z, we_c}, 0);

    // R1: asynchronous reset mid-run
    apply(2'd1, 1'b0, 1'b0, 8'h12, 8'h34);
    chk("R3", "pre-reset add", res_q, 8'h46);
    #3 rst_n = 1'b0;
    #1;
    chk("R1", "async reset result", res_q, 0);
    chk("R1", "async reset enables", {res_we, we_n, we_v, we_z, we_c}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule